// File: doc/BRIEF.md
# Binary32 Fused Negative Multiply-Subtract Unit

This unit computes `-(a*b) - c` for one lane of IEEE binary32 operands. The product is kept exact and is never rounded on its own. It is combined with the negated addend at full precision and rounded once, under a rounding mode supplied with each operation. A vector controller can therefore place one instance per lane. That controller chooses which architectural register feeds `a`, `b` and `c`, applies masking, and accumulates the sticky flags. It can drive the rounding input from a global mode or from a per-instruction override.

The datapath is combinational. A single register stage holds the result and the five exception flags, so a result appears one clock after its operands are presented with `in_valid`. NaN, infinity, zero and subnormal operands are handled completely, and subnormal results are produced with correct rounding.

Top module: `fnmsub32`

## Requirements
- R1: After reset, `out_valid`, `result` and `flags` are all zero. `out_valid` equals `in_valid` delayed by one clock. `result` and `flags` load only on cycles where `in_valid` is high and otherwise hold their value.
- R2: For finite operands, `result` is the binary32 value of `-(a*b) - c` computed exactly and then rounded once. A case where rounding the product on its own would change the answer yields the exactly fused value.
- R3: `rmode` selects the rounding: 0 gives nearest with ties to even, 1 rounds toward minus infinity, 2 rounds toward plus infinity, 3 rounds toward zero.
- R4: When the rounded magnitude exceeds the largest finite value, overflow and inexact are raised. The result is infinity under modes 0, under 1 when negative, and under 2 when positive; otherwise it is the largest finite value of the result's sign.
- R5: Tininess is judged on the exact result before rounding (magnitude below 2^-126). Underflow is raised only when the result is both tiny and inexact, and tiny results are delivered as correctly rounded subnormals.
- R6: Infinity times zero, or an infinite product meeting an infinite negated addend of opposite sign, raises invalid and returns 0x7FC00000.
- R7: If any operand is a NaN, the result is the first NaN in the order a, b, c with bit 22 set. Invalid is raised only if some operand is a signaling NaN (bit 22 clear).
- R8: An exactly zero result is +0 when the two terms have opposite signs (or cancel exactly), except under mode 1, where it is -0. Two terms that are both zero with the same sign keep that sign. A zero product with a nonzero `c` returns `-c` exactly.
- R9: The denormal flag is raised whenever any of a, b or c is subnormal (exponent field 0, fraction nonzero).
- R10: The `flags` bits are: bit 4 invalid, bit 3 denormal operand, bit 2 overflow, bit 1 underflow, bit 0 inexact. Inexact is raised whenever the delivered result differs from the exact one.
- R11: An infinite product, or an infinite `c` with a finite product, yields an exact infinity of the matching sign with no flags apart from denormal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and rounding mode are valid this cycle |
| a | input | 32 | Multiplicand, binary32 |
| b | input | 32 | Multiplier, binary32 |
| c | input | 32 | Addend subtracted from the negated product, binary32 |
| rmode | input | 2 | Rounding mode for this operation |
| out_valid | output | 1 | Result and flags were loaded last cycle |
| result | output | 32 | Rounded binary32 result |
| flags | output | 5 | Exception flags for this operation |

## Verification
The unit keeps no state apart from its output register, so any internal fault shows up at the ports on the very next clock.

- A wrong alignment distance or a wrong swap of the larger term appears as a wrong exponent or wrong fraction bits.
- A lost sticky bit appears as a missing inexact flag, or as a wrong last bit under the directed rounding modes.
- A wrong pick of the effective sign appears as a result of the wrong sign, or a zero of the wrong sign.

The vectors therefore pair each rounding mode with exact-cancellation, far-apart-exponent, halfway-subnormal and overflow cases.

// File: rtl/fnmsub32.sv
module fnmsub32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [31:0] c,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [31:0] result,
  output logic [4:0]  flags
);
  localparam int MW = 24;
  localparam int PW = 2 * MW;
  localparam int G  = 3;
  localparam int FW = PW + G + 1;
  localparam logic [1:0] RM_NE = 2'd0, RM_DN = 2'd1, RM_UP = 2'd2;
  localparam logic [31:0] QNAN = 32'h7FC00000;

  function automatic logic [5:0] lz52(input logic [FW-1:0] v);
    lz52 = 6'(FW);
    for (int i = 0; i < FW; i++) if (v[i]) lz52 = 6'(FW - 1 - i);
  endfunction

  // operand classes
  logic a_zero, b_zero, c_zero, a_inf, b_inf, c_inf, a_nan, b_nan, c_nan, any_snan, den;
  assign a_zero = a[30:0] == 31'd0;
  assign b_zero = b[30:0] == 31'd0;
  assign c_zero = c[30:0] == 31'd0;
  assign a_inf  = a[30:0] == 31'h7F800000;
  assign b_inf  = b[30:0] == 31'h7F800000;
  assign c_inf  = c[30:0] == 31'h7F800000;
  assign a_nan  = a[30:23] == 8'hFF && a[22:0] != 23'd0;
  assign b_nan  = b[30:23] == 8'hFF && b[22:0] != 23'd0;
  assign c_nan  = c[30:23] == 8'hFF && c[22:0] != 23'd0;
  assign any_snan = (a_nan & ~a[22]) | (b_nan & ~b[22]) | (c_nan & ~c[22]);
  assign den = (a[30:23] == 8'd0 && !a_zero) || (b[30:23] == 8'd0 && !b_zero) ||
               (c[30:23] == 8'd0 && !c_zero);

  // effective signs of the two terms being added
  logic sp, scn;
  assign sp  = a[31] ^ b[31] ^ 1'b1;
  assign scn = ~c[31];

  // exact product and addend, each normalised to a 48-bit mantissa
  logic signed [11:0] la, lb, lc, pp, pc;
  logic [MW-1:0] ma, mb, mc;
  logic [PW-1:0] mp, mpn, mcn;
  logic [5:0] lzp, lzc;
  assign la = $signed({4'b0, a[30:23]}) + $signed({11'b0, a[30:23] == 8'd0}) - 12'sd150;
  assign lb = $signed({4'b0, b[30:23]}) + $signed({11'b0, b[30:23] == 8'd0}) - 12'sd150;
  assign lc = $signed({4'b0, c[30:23]}) + $signed({11'b0, c[30:23] == 8'd0}) - 12'sd150;
  assign ma = {a[30:23] != 8'd0, a[22:0]};
  assign mb = {b[30:23] != 8'd0, b[22:0]};
  assign mc = {c[30:23] != 8'd0, c[22:0]};
  assign mp  = ma * mb;
  assign lzp = lz52({mp, 4'hF});
  assign lzc = lz52({mc, 28'hFFFFFFF});
  assign mpn = mp << lzp;
  assign mcn = {mc, 24'd0} << lzc;
  assign pp  = la + lb + 12'sd47 - $signed({6'b0, lzp});
  assign pc  = lc + 12'sd23 - $signed({6'b0, lzc});

  // alignment: larger-leading term stays, the other shifts right with sticky
  logic x_is_p, sx, sy, ystk;
  logic signed [11:0] px, dd;
  logic [6:0] dsh;
  logic [PW-1:0] mx, my;
  logic [FW-1:0] xf, yfull, yf, s;
  logic [FW:0] diff;
  logic rs;
  assign x_is_p = c_zero || pp >= pc;
  assign mx  = x_is_p ? mpn : mcn;
  assign my  = x_is_p ? mcn : mpn;
  assign sx  = x_is_p ? sp : scn;
  assign sy  = x_is_p ? scn : sp;
  assign px  = x_is_p ? pp : pc;
  assign dd  = x_is_p ? pp - pc : pc - pp;
  assign dsh = (dd < 0 || dd > 12'sd60) ? 7'd60 : dd[6:0];
  assign xf    = {1'b0, mx, {G{1'b0}}};
  assign yfull = {1'b0, my, {G{1'b0}}};
  assign ystk  = |(yfull & ((52'd1 << dsh) - 52'd1));
  assign yf    = (yfull >> dsh) | {{(FW-1){1'b0}}, ystk};
  assign diff  = {1'b0, xf} - {1'b0, yf};
  assign s  = (sx == sy) ? xf + yf : (diff[FW] ? yf - xf : diff[FW-1:0]);
  assign rs = (sx != sy && diff[FW]) ? sy : sx;

  // normalise, pick rounding position (clamped to the subnormal quantum), round
  logic [5:0] z, kl;
  logic signed [11:0] e, q, k, qf, bexp;
  logic [6:0] kr, km1;
  logic [24:0] kept, m, mf;
  logic rb, st, inx, inc, tiny, ovf, to_inf;
  assign z    = lz52(s);
  assign e    = px + 12'sd1 - $signed({6'b0, z});
  assign q    = (e - 12'sd23 < -12'sd149) ? -12'sd149 : e - 12'sd23;
  assign k    = q - (px - 12'sd50);
  assign kr   = (k < 0) ? 7'd0 : (k > 12'sd63 ? 7'd63 : k[6:0]);
  assign kl   = 6'(-k);
  assign km1  = kr - 7'd1;
  assign kept = (k < 0) ? 25'(s << kl) : 25'(s >> kr);
  assign rb   = (kr != 7'd0) && |(s & (52'd1 << km1));
  assign st   = (kr > 7'd1) && |(s & ((52'd1 << km1) - 52'd1));
  assign inx  = rb | st;
  always_comb
    case (rmode)
      RM_NE:   inc = rb & (st | kept[0]);
      RM_DN:   inc = inx & rs;
      RM_UP:   inc = inx & ~rs;
      default: inc = 1'b0;
    endcase
  assign m      = kept + {24'd0, inc};
  assign mf     = m[24] ? 25'h0800000 : m;
  assign qf     = q + $signed({11'b0, m[24]});
  assign bexp   = qf + 12'sd150;
  assign ovf    = mf[23] && bexp > 12'sd254;
  assign tiny   = e < -12'sd126;
  assign to_inf = rmode == RM_NE || (rmode == RM_DN && rs) || (rmode == RM_UP && !rs);

  // special-value priority, then the arithmetic path
  logic [31:0] res_c;
  logic [4:0]  flg_c;
  always_comb begin
    flg_c = {1'b0, den, 3'b000};
    if (a_nan || b_nan || c_nan) begin
      res_c = (a_nan ? a : (b_nan ? b : c)) | 32'h00400000;
      flg_c[4] = any_snan;
    end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
      res_c = QNAN;
      flg_c[4] = 1'b1;
    end else if (a_inf || b_inf) begin
      if (c_inf && scn != sp) begin
        res_c = QNAN;
        flg_c[4] = 1'b1;
      end else res_c = {sp, 31'h7F800000};
    end else if (c_inf) begin
      res_c = {scn, 31'h7F800000};
    end else if (a_zero || b_zero) begin
      if (c_zero) res_c = {(sp == scn) ? sp : (rmode == RM_DN), 31'd0};
      else        res_c = {scn, c[30:0]};
    end else if (s == '0) begin
      res_c = {rmode == RM_DN, 31'd0};
    end else if (ovf) begin
      res_c = to_inf ? {rs, 31'h7F800000} : {rs, 31'h7F7FFFFF};
      flg_c[2] = 1'b1;
      flg_c[0] = 1'b1;
    end else begin
      res_c = {rs, mf[23] ? bexp[7:0] : 8'd0, mf[22:0]};
      flg_c[1] = tiny & inx;
      flg_c[0] = inx;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        flags  <= flg_c;
      end
    end
endmodule

// File: rtl/fnmsub32_chk.sv
module fnmsub32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] a,
  input logic [31:0] result,
  input logic [4:0]  flags,
  input logic        out_valid
);
  logic res_nan;
  assign res_nan = result[30:23] == 8'hFF && result[22:0] != 23'd0;

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flags));
  assert_ovf_inexact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> flags[0]);
  assert_unf_inexact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> flags[0]);
  assert_invalid_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] |-> res_nan);
  assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_nan |-> result[22]);
  assert_snan_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a[30:22] == 9'b111111110 && a[21:0] != 22'd0 |=> flags[4]);
  assert_den_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a[30:23] == 8'd0 && a[22:0] != 23'd0 |=> flags[3]);
endmodule

bind fnmsub32 fnmsub32_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a),
  .result(result), .flags(flags), .out_valid(out_valid)
);

// File: tb/sim_fnmsub32.sv
module sim_fnmsub32;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;
  // {tag, a, b, c, rmode, expected result, expected flags}
  localparam logic [138:0] VEC [NV] = '{
    {4'd2,  32'h40000000, 32'h40400000, 32'h3F800000, 2'd0, 32'hC0E00000, 5'h00}, // R2
    {4'd2,  32'hC0000000, 32'h40400000, 32'h3F800000, 2'd0, 32'h40A00000, 5'h00}, // R2
    {4'd2,  32'h3F800000, 32'h3F800000, 32'hC0400000, 2'd0, 32'h40000000, 5'h00}, // R2
    {4'd2,  32'h40400000, 32'h3F800000, 32'hBF800000, 2'd0, 32'hC0000000, 5'h00}, // R2
    {4'd2,  32'h3F800001, 32'h3F800001, 32'hBF800002, 2'd0, 32'hA8800000, 5'h00}, // R2 fused
    {4'd3,  32'h3F800001, 32'h3F800001, 32'h00000000, 2'd0, 32'hBF800002, 5'h01}, // R3
    {4'd3,  32'h3F800001, 32'h3F800001, 32'h00000000, 2'd1, 32'hBF800003, 5'h01}, // R3
    {4'd3,  32'h3F800001, 32'h3F800001, 32'h00000000, 2'd2, 32'hBF800002, 5'h01}, // R3
    {4'd3,  32'h3F800001, 32'h3F800001, 32'h00000000, 2'd3, 32'hBF800002, 5'h01}, // R3
    {4'd4,  32'h7F7FFFFF, 32'h40000000, 32'h00000000, 2'd0, 32'hFF800000, 5'h05}, // R4
    {4'd4,  32'h7F7FFFFF, 32'h40000000, 32'h00000000, 2'd3, 32'hFF7FFFFF, 5'h05}, // R4
    {4'd4,  32'h7F7FFFFF, 32'h40000000, 32'h00000000, 2'd2, 32'hFF7FFFFF, 5'h05}, // R4
    {4'd4,  32'h7F7FFFFF, 32'h40000000, 32'h00000000, 2'd1, 32'hFF800000, 5'h05}, // R4
    {4'd5,  32'h00000001, 32'h3F000000, 32'h00000000, 2'd0, 32'h80000000, 5'h0B}, // R5
    {4'd5,  32'h00000001, 32'h3F000000, 32'h00000000, 2'd1, 32'h80000001, 5'h0B}, // R5
    {4'd5,  32'h00800000, 32'h3F000000, 32'h00000000, 2'd0, 32'h80400000, 5'h00}, // R5
    {4'd6,  32'h7F800000, 32'h00000000, 32'h3F800000, 2'd0, 32'h7FC00000, 5'h10}, // R6
    {4'd6,  32'h7F800000, 32'h3F800000, 32'hFF800000, 2'd0, 32'h7FC00000, 5'h10}, // R6
    {4'd11, 32'h7F800000, 32'h3F800000, 32'h7F800000, 2'd0, 32'hFF800000, 5'h00}, // R11
    {4'd11, 32'h40000000, 32'h40400000, 32'hFF800000, 2'd0, 32'h7F800000, 5'h00}, // R11
    {4'd7,  32'h7F800001, 32'h3F800000, 32'h3F800000, 2'd0, 32'h7FC00001, 5'h10}, // R7
    {4'd7,  32'h3F800000, 32'h3F800000, 32'h7FC12345, 2'd0, 32'h7FC12345, 5'h00}, // R7
    {4'd7,  32'h3F800000, 32'hFF800001, 32'h7FC00005, 2'd0, 32'hFFC00001, 5'h10}, // R7
    {4'd8,  32'h40000000, 32'h40400000, 32'hC0C00000, 2'd0, 32'h00000000, 5'h00}, // R8
    {4'd8,  32'h40000000, 32'h40400000, 32'hC0C00000, 2'd1, 32'h80000000, 5'h00}, // R8
    {4'd8,  32'h00000000, 32'h3F800000, 32'h00000000, 2'd0, 32'h80000000, 5'h00}, // R8
    {4'd8,  32'h00000000, 32'h3F800000, 32'h80000000, 2'd0, 32'h00000000, 5'h00}, // R8
    {4'd8,  32'h00000000, 32'h3F800000, 32'h80000000, 2'd1, 32'h80000000, 5'h00}, // R8
    {4'd8,  32'h00000000, 32'h40A00000, 32'h40400000, 2'd0, 32'hC0400000, 5'h00}, // R8
    {4'd9,  32'h00000001, 32'h3F800000, 32'h00000000, 2'd0, 32'h80000001, 5'h08}, // R9
    {4'd9,  32'h00000001, 32'h00000001, 32'h3F800000, 2'd0, 32'hBF800000, 5'h09}, // R9 R10
    {4'd3,  32'h00000001, 32'h00000001, 32'h3F800000, 2'd1, 32'hBF800001, 5'h09}  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [1:0] rmode = '0;
  logic out_valid;
  logic [31:0] result;
  logic [4:0] flags;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fnmsub32 u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
               .rmode(rmode), .out_valid(out_valid), .result(result), .flags(flags));

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ia, ib, ic, input logic [1:0] rm);
    @(negedge clk);
    a = ia; b = ib; c = ic; rmode = rm; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 1);
    check("R1 reset", {out_valid, result, flags}, 38'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][134:103], VEC[i][102:71], VEC[i][70:39], VEC[i][38:37]);
      check($sformatf("R%0d vector %0d", VEC[i][138:135], i), {out_valid, result, flags},
            {1'b1, VEC[i][36:5], VEC[i][4:0]});
    end
    // R1: idle cycle with new operands on the inputs: output held, valid low
    @(negedge clk);
    a = 32'h40000000; b = 32'h40000000; c = 32'h40000000; in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R1 hold", {out_valid, result, flags}, {1'b0, 32'hBF800001, 5'h09});
    // R1: asynchronous reset clears the outputs again
    rst_n = 1'b0;
    #1;
    check("R1 reset again", {out_valid, result, flags}, 38'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule